// File: doc/BRIEF.md
# Gap-Coded RFID Downlink Writer

This block sends one reader-to-tag command over a low-frequency link by switching the carrier on and off. Each command bit is coded as a length of carrier-on time. A fixed carrier-off gap follows every bit. A free-running tick, nominally one per microsecond, sets the pace. Every duration is a parameter counted in ticks, so the timing can be retuned to suit the antenna's rise and fall times.

A command request is taken through a valid/ready handshake. The request carries an operation code, an optional 32-bit password with its enable, a 32-bit data word and a 3-bit block address.

The block runs the full framing sequence:
- a long powered settle period, then a start gap;
- the opcode bits, then the optional password;
- the lock bit, the data and the address;
- a final carrier-on phase.

After a write, the final phase is a programming hold. After a read, it is a receive window that the capture path can use. A one-cycle `done` pulse marks the end of each command.

Top module: `rfid_gap_writer`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the cycle of `done`. Requests presented while busy are ignored and do not change the carrier waveform.
- R2: After acceptance, `field_en` is high for SETTLE_TICKS ticks and then low for START_TICKS ticks.
- R3: A 0 bit is ZERO_TICKS ticks of `field_en` high and a 1 bit is ONE_TICKS ticks high. Each bit is followed by GAP_TICKS ticks low. The number of carrier pulses matches the frame length.
- R4: `req_op` encodes 0 = block write, 1 = block read, 2 = trace-page read, 3 = handled as block read. The first bit sent is always 1. The second bit is the page bit: 1 for the trace read and 0 otherwise.
- R5: For block operations with `req_pwd_en` high, the 32 password bits follow the page bit, most significant bit first.
- R6: Block operations then send a lock bit of 0. A write next sends the 32 data bits, MSB first. Both write and read end the frame with the 3 address bits, MSB first.
- R7: A trace-page read sends only the two opcode bits. The password, data and address are ignored.
- R8: After the last gap of a write, `field_en` is high for PROG_TICKS ticks. It then drops in the same cycle as a single-cycle `done` pulse, and `rx_window` stays low for the whole command.
- R9: After the last gap of a read, `field_en` and `rx_window` are both high for RX_TICKS ticks. Both drop in the cycle of a single-cycle `done` pulse.
- R10: Durations advance only on cycles where `tick` is high. At a slower tick rate, every phase stretches in proportion.
- R11: During and right after reset, `field_en`, `rx_window` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one per time unit |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | High when a request can be taken |
| req_op | input | 2 | Operation code (see R4) |
| req_pwd_en | input | 1 | Send the password field |
| req_pwd | input | 32 | Password, sent MSB first |
| req_data | input | 32 | Write data, sent MSB first |
| req_addr | input | 3 | Block address, sent MSB first |
| field_en | output | 1 | Carrier enable |
| rx_window | output | 1 | Reply capture window after a read |
| done | output | 1 | One-cycle pulse at command end |

## Verification
The assertions assume that every duration parameter is at least one tick. They also assume that `tick` keeps arriving, so each phase ends. The `done` and receive-window checks rest on that.

The stimulus keeps `tick` high on every cycle, or toggling on alternate cycles for the slow-rate case. Request fields are changed only after acceptance or while busy, so that the capture at acceptance is what gets tested. The stretched-time case is checked with a tolerance of two cycles for the tick phase.

// File: rtl/gw_pkg.sv
package gw_pkg;

    localparam int unsigned PWD_W   = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 3;
    // opcode (2) + password + lock (1) + data + address
    localparam int unsigned FRAME_W = 2 + PWD_W + 1 + DATA_W + ADDR_W;
    localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

    localparam logic [1:0] OP_WRITE = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_TRACE = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_START,
        ST_BIT_ON,
        ST_BIT_GAP,
        ST_PROG,
        ST_RX
    } gw_state_e;

    typedef struct packed {
        gw_state_e            st;
        logic [FRAME_W-1:0]   frame;
        logic [LEN_W-1:0]     left;
        logic                 wr;
        logic                 done;
    } gw_regs_t;

    function automatic int unsigned gw_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gw_frame_build.sv
module gw_frame_build
    import gw_pkg::*;
(
    input  logic [1:0]         op,
    input  logic               pwd_en,
    input  logic [PWD_W-1:0]   pwd,
    input  logic [DATA_W-1:0]  data,
    input  logic [ADDR_W-1:0]  addr,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   len
);

    logic [FRAME_W-1:0] acc;
    logic [LEN_W-1:0]   n;
    logic               is_trace;
    logic               is_write;

    // Bits accumulate right-aligned, then the frame is left-aligned so that
    // the sequencer always transmits bit FRAME_W-1.
    always_comb begin
        is_trace = (op == OP_TRACE);
        is_write = (op == OP_WRITE);
        acc      = FRAME_W'({1'b1, is_trace});
        n        = LEN_W'(2);
        if (!is_trace) begin
            if (pwd_en) begin
                acc = (acc << PWD_W) | FRAME_W'(pwd);
                n   = n + LEN_W'(PWD_W);
            end
            acc = acc << 1;                     // lock bit, always 0
            n   = n + LEN_W'(1);
            if (is_write) begin
                acc = (acc << DATA_W) | FRAME_W'(data);
                n   = n + LEN_W'(DATA_W);
            end
            acc = (acc << ADDR_W) | FRAME_W'(addr);
            n   = n + LEN_W'(ADDR_W);
        end
        frame = acc << (LEN_W'(FRAME_W) - n);
        len   = n;
    end

endmodule

// File: rtl/gw_dur_timer.sv
module gw_dur_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/rfid_gap_writer.sv
module rfid_gap_writer
    import gw_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 150000,
    parameter int unsigned START_TICKS  = 250,
    parameter int unsigned ZERO_TICKS   = 144,
    parameter int unsigned ONE_TICKS    = 400,
    parameter int unsigned GAP_TICKS    = 160,
    parameter int unsigned PROG_TICKS   = 20000,
    parameter int unsigned RX_TICKS     = 4096
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [1:0]   req_op,
    input  logic         req_pwd_en,
    input  logic [31:0]  req_pwd,
    input  logic [31:0]  req_data,
    input  logic [2:0]   req_addr,
    output logic         field_en,
    output logic         rx_window,
    output logic         done
);

    localparam int unsigned MAX_T = gw_max(gw_max(gw_max(SETTLE_TICKS, START_TICKS),
                                                  gw_max(ZERO_TICKS, ONE_TICKS)),
                                           gw_max(gw_max(GAP_TICKS, PROG_TICKS), RX_TICKS));
    localparam int unsigned CNT_W = $clog2(MAX_T + 1);

    // Each phase loads its length minus one: the state change costs one cycle.
    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_START  = CNT_W'(START_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_ZERO   = CNT_W'(ZERO_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_ONE    = CNT_W'(ONE_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_GAP    = CNT_W'(GAP_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_PROG   = CNT_W'(PROG_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_RX     = CNT_W'(RX_TICKS - 1);

    gw_regs_t           r_d, r_q;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_exp;
    logic [FRAME_W-1:0] fb_frame;
    logic [LEN_W-1:0]   fb_len;
    logic               cur_bit;

    gw_frame_build u_frame (
        .op     (req_op),
        .pwd_en (req_pwd_en),
        .pwd    (req_pwd),
        .data   (req_data),
        .addr   (req_addr),
        .frame  (fb_frame),
        .len    (fb_len)
    );

    gw_dur_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cur_bit  = r_q.frame[FRAME_W-1];
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_SETTLE;
                    r_d.frame = fb_frame;
                    r_d.left  = fb_len;
                    r_d.wr    = (req_op == OP_WRITE);
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    r_d.st   = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = LD_START;
                end
            end
            ST_START: begin
                if (tmr_exp) begin
                    r_d.st   = ST_BIT_ON;
                    tmr_load = 1'b1;
                    tmr_val  = cur_bit ? LD_ONE : LD_ZERO;
                end
            end
            ST_BIT_ON: begin
                if (tmr_exp) begin
                    r_d.st    = ST_BIT_GAP;
                    r_d.frame = r_q.frame << 1;
                    r_d.left  = r_q.left - LEN_W'(1);
                    tmr_load  = 1'b1;
                    tmr_val   = LD_GAP;
                end
            end
            ST_BIT_GAP: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (r_q.left != '0) begin
                        r_d.st  = ST_BIT_ON;
                        tmr_val = cur_bit ? LD_ONE : LD_ZERO;
                    end else if (r_q.wr) begin
                        r_d.st  = ST_PROG;
                        tmr_val = LD_PROG;
                    end else begin
                        r_d.st  = ST_RX;
                        tmr_val = LD_RX;
                    end
                end
            end
            ST_PROG, ST_RX: begin
                if (tmr_exp) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.frame <= '0;
            r_q.left  <= '0;
            r_q.wr    <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign field_en  = (r_q.st == ST_SETTLE) || (r_q.st == ST_BIT_ON) ||
                       (r_q.st == ST_PROG)   || (r_q.st == ST_RX);
    assign rx_window = (r_q.st == ST_RX);
    assign done      = r_q.done;

endmodule

// File: rtl/gw_writer_checker.sv
module gw_writer_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic field_en,
    input logic rx_window,
    input logic done
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!field_en && !rx_window));

    a_r2_accept_starts_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && field_en));

    a_r9_rx_needs_field: assert property (@(posedge clk) disable iff (!rst_n)
        rx_window |-> field_en);

    a_r9_rx_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_window) |-> done);

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ends_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(field_en) && !field_en && req_ready));

endmodule

bind rfid_gap_writer gw_writer_checker u_gw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .field_en  (field_en),
    .rx_window (rx_window),
    .done      (done)
);

// File: tb/rfid_gap_writer_test.sv
`timescale 1ns/1ps
module rfid_gap_writer_test;

    localparam int T_SET = 20;
    localparam int T_ST  = 6;
    localparam int T_Z   = 3;
    localparam int T_O   = 7;
    localparam int T_G   = 4;
    localparam int T_P   = 15;
    localparam int T_RX  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    int          tick_div = 1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic        req_pwd_en = 1'b0;
    logic [31:0] req_pwd = '0;
    logic [31:0] req_data = '0;
    logic [2:0]  req_addr = '0;
    logic        field_en;
    logic        rx_window;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    int    act_len [0:159];
    logic  act_lvl [0:159];
    int    act_n, cur, rx_cnt, done_cnt;
    logic  prev;
    bit    mon_on = 1'b0;

    int    exp_len [0:159];
    logic  exp_lvl [0:159];
    string exp_tag [0:159];
    int    exp_n;

    rfid_gap_writer #(
        .SETTLE_TICKS(T_SET), .START_TICKS(T_ST), .ZERO_TICKS(T_Z),
        .ONE_TICKS(T_O), .GAP_TICKS(T_G), .PROG_TICKS(T_P), .RX_TICKS(T_RX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_pwd_en(req_pwd_en), .req_pwd(req_pwd), .req_data(req_data),
        .req_addr(req_addr), .field_en(field_en), .rx_window(rx_window),
        .done(done)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (tick_div > 1) tick <= ~tick;
        else              tick <= 1'b1;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (field_en !== prev) begin
                if (act_n < 160) begin
                    act_lvl[act_n] = prev;
                    act_len[act_n] = cur;
                end
                act_n++;
                prev = field_en;
                cur  = 1;
            end else begin
                cur++;
            end
            if (rx_window) rx_cnt++;
            if (done) done_cnt++;
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic push(logic l, int len, string tag);
        exp_lvl[exp_n] = l;
        exp_len[exp_n] = len;
        exp_tag[exp_n] = tag;
        exp_n++;
    endtask

    task automatic push_bit(logic b, string tag);
        push(1'b1, b ? T_O : T_Z, tag);
        push(1'b0, T_G, tag);
    endtask

    task automatic build_exp(logic [1:0] op, bit pe, logic [31:0] pwd,
                             logic [31:0] data, logic [2:0] addr);
        exp_n = 1;                                  // index 0: idle low run
        push(1'b1, T_SET, "R2");
        push(1'b0, T_ST, "R2");
        push_bit(1'b1, (op == 2'd2) ? "R7" : "R4");
        push_bit(op == 2'd2, (op == 2'd2) ? "R7" : "R4");
        if (op != 2'd2) begin
            if (pe) for (int i = 31; i >= 0; i--) push_bit(pwd[i], "R5");
            push_bit(1'b0, "R6");
            if (op == 2'd0) for (int i = 31; i >= 0; i--) push_bit(data[i], "R6");
            for (int i = 2; i >= 0; i--) push_bit(addr[i], "R6");
        end
        push(1'b1, (op == 2'd0) ? T_P : T_RX, (op == 2'd0) ? "R8" : "R9");
    endtask

    task automatic run_cmd(logic [1:0] op, bit pe, logic [31:0] pwd,
                           logic [31:0] data, logic [2:0] addr, int div, bit poke);
        int w;
        int lim;
        tick_div = div;
        @(posedge clk); #1;
        act_n = 0; cur = 0; prev = 1'b0; rx_cnt = 0; done_cnt = 0; mon_on = 1'b1;
        req_valid = 1'b1; req_op = op; req_pwd_en = pe;
        req_pwd = pwd; req_data = data; req_addr = addr;
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_pwd = ~pwd; req_data = ~data; req_addr = ~addr; req_op = op ^ 2'd1;
        chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
        if (poke) begin
            repeat (5) @(posedge clk);
            #1 req_valid = 1'b1; req_op = 2'd0; req_pwd_en = 1'b1;
            repeat (30) @(posedge clk);
            #1 req_valid = 1'b0;
        end
        w = 0;
        while (!done && w < 6000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 6000, "R1", "command completes", w, 0);
        @(negedge clk);
        mon_on = 1'b0;
        #1;
        build_exp(op, pe, pwd, data, addr);
        chk(act_n == exp_n, "R3", "carrier run count", act_n, exp_n);
        lim = (act_n < exp_n) ? act_n : exp_n;
        if (lim > 160) lim = 160;
        for (int i = 1; i < lim; i++) begin
            chk(act_lvl[i] == exp_lvl[i], exp_tag[i], "run level", act_lvl[i], exp_lvl[i]);
            if (div == 1)
                chk(act_len[i] == exp_len[i], exp_tag[i], "run length", act_len[i], exp_len[i]);
            else
                chk((act_len[i] >= 2*exp_len[i] - 2) && (act_len[i] <= 2*exp_len[i] + 2),
                    "R10", "stretched run length", act_len[i], 2*exp_len[i]);
        end
        if (div == 1)
            chk(rx_cnt == ((op == 2'd0) ? 0 : T_RX), (op == 2'd0) ? "R8" : "R9",
                "rx_window cycles", rx_cnt, (op == 2'd0) ? 0 : T_RX);
        chk(done_cnt == 1, (op == 2'd0) ? "R8" : "R9", "done pulses", done_cnt, 1);
        chk(req_ready == 1'b1, "R1", "ready after done", req_ready, 1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
            finish_run();
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd1357);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(field_en == 1'b0, "R11", "field_en in reset", field_en, 0);
        chk(rx_window == 1'b0, "R11", "rx_window in reset", rx_window, 0);
        chk(done == 1'b0, "R11", "done in reset", done, 0);
        chk(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(field_en == 1'b0 && req_ready == 1'b1, "R11", "idle after reset", field_en, 0);

        // directed corners
        run_cmd(2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 3'd7, 1, 1'b0);
        run_cmd(2'd0, 1'b0, 32'h1234_5678, 32'hA5C3_0F81, 3'd0, 1, 1'b0);
        run_cmd(2'd1, 1'b0, 32'h0,         32'hDEAD_BEEF, 3'd5, 1, 1'b0);
        run_cmd(2'd1, 1'b1, 32'h8000_0001, 32'h0,         3'd2, 1, 1'b0);
        run_cmd(2'd2, 1'b1, 32'hFFFF_0000, 32'hFFFF_FFFF, 3'd6, 1, 1'b0);  // R7
        run_cmd(2'd3, 1'b0, 32'h0,         32'h0,         3'd3, 1, 1'b0);  // R4 op 3
        run_cmd(2'd2, 1'b0, 32'h0,         32'h0,         3'd0, 1, 1'b1);  // R1 busy poke
        run_cmd(2'd1, 1'b1, 32'h0F0F_00FF, 32'h0,         3'd4, 1, 1'b1);  // R1 busy poke
        run_cmd(2'd0, 1'b0, 32'h0,         32'h6B1E_93C4, 3'd1, 2, 1'b0);  // R10
        run_cmd(2'd2, 1'b0, 32'h0,         32'h0,         3'd0, 2, 1'b0);  // R10

        // constrained random
        for (int k = 0; k < 16; k++) begin
            run_cmd(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom(), $urandom(),
                    3'($urandom_range(0, 7)), 1, 1'($urandom_range(0, 1)));
        end
        finish_run();
    end

endmodule